// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block sits beside the core of a small 8-bit microcontroller. It holds the interrupt enable byte and the timer/external-interrupt control byte. It turns six request sources into one vector request for the core. The sources are:

- two active-low external pins;
- three timer overflow pulses;
- a serial-port request level.

Software writes the two bytes through plain write strobes and can read both back. Hardware sets the request flags as events arrive. The block masks them with the per-source enables and a global gate. It then presents the highest-priority survivor as an index plus a vector address.

When the core takes the vector (`vec_ack`), the block clears the flag of that source where the flag is hardware-cleared. It then issues nothing more until the core signals return from the service routine with `vec_done`.

Each external pin selects between two modes. In edge mode a falling edge is latched and held until serviced. In level mode the flag simply mirrors the synchronized pin.

The timers themselves, priority-level programming and serial-port logic live elsewhere.

Top module: `irq_ctrl`

## Requirements
- R1: After reset `en_q` and `ctl_q` read 0x00 and `vec_req` is low.
- R2: A write with `en_we` loads `en_wdata` into `en_q`, except bit 6, which is reserved and always reads 0.
- R3: While `en_q[7]` (global gate) is 0, `vec_req` stays low whatever is pending.
- R4: With the gate set, source i may request only when `en_q[i]` is 1. The source indices are: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2.
- R5: Of several enabled pending sources, the lowest index wins. `vec_idx` gives that index and `vec_addr` equals 8*index+3 (0x03, 0x0B, 0x13, 0x1B, 0x23, 0x2B).
- R6: When the type bit is 1 (`ctl_q[0]` for external 0, `ctl_q[2]` for external 1), a falling pin edge sets the flag (`ctl_q[1]` or `ctl_q[3]`). The flag stays set after the pin returns high and is cleared when that source is acknowledged.
- R7: When the type bit is 0, the flag equals the inverted synchronized pin. It does not latch, and an acknowledge does not clear it.
- R8: A timer overflow pulse sets its flag (`ctl_q[5]` timer 0, `ctl_q[7]` timer 1, an internal flag for timer 2). Acknowledging that source clears it. An overflow in the same cycle as an acknowledge or a control write wins, and leaves the flag set.
- R9: A write with `ctl_we` loads the run bits (`ctl_q[6]` timer 1, `ctl_q[4]` timer 0) and the type bits exactly as written.
- R10: The serial request follows `ser_req` and is not cleared by an acknowledge.
- R11: After `vec_req` is acknowledged, `vec_req` stays low until a `vec_done` pulse. Events arriving in between remain pending and are offered afterwards.
- R12: Each external pin passes through a two-flop synchronizer. A pin change driven before a clock edge shows in its flag after the third edge, not the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext0_n | input | 1 | External interrupt pin 0, active low, asynchronous |
| ext1_n | input | 1 | External interrupt pin 1, active low, asynchronous |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow or capture pulse |
| ser_req | input | 1 | Serial-port request level |
| en_we | input | 1 | Enable byte write strobe |
| en_wdata | input | 8 | Enable byte write data |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| en_q | output | 8 | Enable byte contents |
| ctl_q | output | 8 | Control byte contents, including live flags |
| vec_req | output | 1 | Vector request to the core |
| vec_idx | output | 3 | Index of the requesting source |
| vec_addr | output | 8 | Vector address of the requesting source |
| vec_ack | input | 1 | Core takes the offered vector |
| vec_done | input | 1 | Return-from-interrupt release pulse |

## Verification
The arbitration path is driven through a table in which groups of timer overflows and the serial level arrive together under different enable masks. This separates three failure sources:
- the global gate;
- a single missing per-source enable;
- a wrong priority order, where a higher-index source would win.

The external pins are tried twice: once with a pulse that returns high before being serviced, in both edge and level modes, which tells latching from mirroring, and once held low across an acknowledge, which tells a hardware-cleared flag from a live one.

Two further patterns check the remaining rules:
- An overflow that coincides with an acknowledge, and one that coincides with a control write, show which update wins.
- An event raised during service, and the serial request, show that the in-service block holds and that the serial request is not cleared.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 6;
  localparam int IDXW = $clog2(NSRC);

  typedef enum logic [IDXW-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4,
    SRC_TMR2 = 3'd5
  } src_e;

  // control byte bit positions
  localparam int CB_TYPE0 = 0;
  localparam int CB_FLAG0 = 1;
  localparam int CB_TYPE1 = 2;
  localparam int CB_FLAG1 = 3;
  localparam int CB_TF0   = 5;
  localparam int CB_TF1   = 7;

  // enable byte
  localparam int EB_GATE = 7;
  localparam logic [7:0] EB_WMASK = 8'hBF;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic q1, q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign rst_sync_n = q2;
endmodule

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic low,
  output logic fall
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic prev_q, prev_d;

  always_comb begin
    sh_d   = {sh_q[STAGES-2:0], pin_n};
    prev_d = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  assign low  = ~sh_q[STAGES-1];
  assign fall = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 6,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  act,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |act;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STRIDE  = 8,
  parameter int AW          = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext0_n,
  input  logic            ext1_n,
  input  logic            tmr0_ovf,
  input  logic            tmr1_ovf,
  input  logic            tmr2_ovf,
  input  logic            ser_req,
  input  logic            en_we,
  input  logic [7:0]      en_wdata,
  input  logic            ctl_we,
  input  logic [7:0]      ctl_wdata,
  output logic [7:0]      en_q,
  output logic [7:0]      ctl_q,
  output logic            vec_req,
  output logic [IDXW-1:0] vec_idx,
  output logic [AW-1:0]   vec_addr,
  input  logic            vec_ack,
  input  logic            vec_done
);
  localparam int NEXT = 2;

  logic rst_sync_n;
  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  logic [NEXT-1:0] pin_n, pin_low, pin_fall;
  assign pin_n = {ext1_n, ext0_n};

  for (genvar g = 0; g < NEXT; g++) begin : g_pin
    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .pin_n(pin_n[g]),
      .low  (pin_low[g]),
      .fall (pin_fall[g])
    );
  end

  logic [7:0] en_r, en_d;
  logic [7:0] ctl_r, ctl_d;
  logic       tf2_r, tf2_d;
  logic       busy_r, busy_d;

  logic [NSRC-1:0] pend, act, clr;
  logic            any;
  logic [IDXW-1:0] pick;
  logic            take;

  assign pend = {tf2_r, ser_req, ctl_r[CB_TF1], ctl_r[CB_FLAG1],
                 ctl_r[CB_TF0], ctl_r[CB_FLAG0]};
  assign act  = pend & en_r[NSRC-1:0] & {NSRC{en_r[EB_GATE]}};

  irq_prio_pick #(.N(NSRC), .IW(IDXW)) u_pick (
    .act(act),
    .any(any),
    .idx(pick)
  );

  assign take = any & ~busy_r & vec_ack;

  for (genvar s = 0; s < NSRC; s++) begin : g_clr
    assign clr[s] = take & (pick == IDXW'(s));
  end

  always_comb begin
    en_d = en_r;
    if (en_we) en_d = en_wdata & EB_WMASK;

    ctl_d = ctl_r;
    if (ctl_we) ctl_d = ctl_wdata;

    // external 0
    if (ctl_r[CB_TYPE0]) begin
      if (clr[SRC_EXT0])  ctl_d[CB_FLAG0] = 1'b0;
      if (pin_fall[0])    ctl_d[CB_FLAG0] = 1'b1;
    end else begin
      ctl_d[CB_FLAG0] = pin_low[0];
    end

    // external 1
    if (ctl_r[CB_TYPE1]) begin
      if (clr[SRC_EXT1])  ctl_d[CB_FLAG1] = 1'b0;
      if (pin_fall[1])    ctl_d[CB_FLAG1] = 1'b1;
    end else begin
      ctl_d[CB_FLAG1] = pin_low[1];
    end

    // timers: overflow wins over clear and write
    if (clr[SRC_TMR0]) ctl_d[CB_TF0] = 1'b0;
    if (tmr0_ovf)      ctl_d[CB_TF0] = 1'b1;
    if (clr[SRC_TMR1]) ctl_d[CB_TF1] = 1'b0;
    if (tmr1_ovf)      ctl_d[CB_TF1] = 1'b1;

    tf2_d = tf2_r;
    if (clr[SRC_TMR2]) tf2_d = 1'b0;
    if (tmr2_ovf)      tf2_d = 1'b1;

    busy_d = busy_r;
    if (take)          busy_d = 1'b1;
    else if (vec_done) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_r   <= '0;
      ctl_r  <= '0;
      tf2_r  <= 1'b0;
      busy_r <= 1'b0;
    end else begin
      en_r   <= en_d;
      ctl_r  <= ctl_d;
      tf2_r  <= tf2_d;
      busy_r <= busy_d;
    end
  end

  assign en_q     = en_r;
  assign ctl_q    = ctl_r;
  assign vec_req  = any & ~busy_r;
  assign vec_idx  = pick;
  assign vec_addr = AW'(VEC_BASE + int'(pick) * VEC_STRIDE);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] en_q,
  input logic       tf0,
  input logic       tmr0_ovf,
  input logic       ctl_we,
  input logic       ctl_wd_tf0,
  input logic       vec_req,
  input logic [2:0] vec_idx,
  input logic [7:0] vec_addr,
  input logic       vec_ack,
  input logic       vec_done
);
  assert_resv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[6] == 1'b0);

  assert_gate_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[7] |-> !vec_req);

  assert_enabled_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> en_q[vec_idx]);

  assert_addr_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (vec_addr[2:0] == 3'b011 && vec_addr[7:6] == 2'b00));

  assert_tmr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_ovf |=> tf0);

  assert_tmr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && vec_ack && vec_idx == 3'd1 && !tmr0_ovf &&
     !(ctl_we && ctl_wd_tf0)) |=> !tf0);

  assert_hold_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && vec_ack && !vec_done) |=> !vec_req);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .en_q      (en_q),
  .tf0       (ctl_q[5]),
  .tmr0_ovf  (tmr0_ovf),
  .ctl_we    (ctl_we),
  .ctl_wd_tf0(ctl_wdata[5]),
  .vec_req   (vec_req),
  .vec_idx   (vec_idx),
  .vec_addr  (vec_addr),
  .vec_ack   (vec_ack),
  .vec_done  (vec_done)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int NVEC       = 10;

  // entry: {en[7:0], src{ser,t2,t1,t0}[3:0], req, idx[2:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h82, 4'b0001, 1'b1, 3'd1},
    {8'h02, 4'b0001, 1'b0, 3'd0},
    {8'hBF, 4'b0111, 1'b1, 3'd1},
    {8'hBF, 4'b0110, 1'b1, 3'd3},
    {8'hA0, 4'b0110, 1'b1, 3'd5},
    {8'h90, 4'b1000, 1'b1, 3'd4},
    {8'hBF, 4'b1100, 1'b1, 3'd4},
    {8'h88, 4'b0001, 1'b0, 3'd0},
    {8'hC8, 4'b0010, 1'b1, 3'd3},
    {8'h80, 4'b1111, 1'b0, 3'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext0_n = 1'b1, ext1_n = 1'b1;
  logic tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, tmr2_ovf = 1'b0, ser_req = 1'b0;
  logic en_we = 1'b0, ctl_we = 1'b0;
  logic [7:0] en_wdata = '0, ctl_wdata = '0;
  logic vec_ack = 1'b0, vec_done = 1'b0;
  logic [7:0] en_q, ctl_q, vec_addr;
  logic [2:0] vec_idx;
  logic vec_req;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext0_n(ext0_n), .ext1_n(ext1_n),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .tmr2_ovf(tmr2_ovf),
    .ser_req(ser_req), .en_we(en_we), .en_wdata(en_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .en_q(en_q), .ctl_q(ctl_q),
    .vec_req(vec_req), .vec_idx(vec_idx), .vec_addr(vec_addr),
    .vec_ack(vec_ack), .vec_done(vec_done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_en(input logic [7:0] d);
    en_we = 1'b1; en_wdata = d;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic ack();
    vec_ack = 1'b1;
    @(negedge clk);
    vec_ack = 1'b0;
  endtask

  task automatic done();
    vec_done = 1'b1;
    @(negedge clk);
    vec_done = 1'b0;
  endtask

  task automatic drain();
    done();
    wr_en(8'hBF);
    for (int k = 0; k < 8; k++) begin
      if (vec_req) begin
        ack();
        done();
      end
    end
    wr_ctl(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 en_q", en_q, 8'h00);
    chk("R1 ctl_q", ctl_q, 8'h00);
    chk("R1 vec_req", vec_req, 1'b0);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] e;
      logic [3:0] s;
      e = VEC[v][15:8];
      s = VEC[v][7:4];
      drain();
      wr_en(e);
      chk("R2 en_q readback", en_q, e & 8'hBF);
      tmr0_ovf = s[0]; tmr1_ovf = s[1]; tmr2_ovf = s[2]; ser_req = s[3];
      @(negedge clk);
      tmr0_ovf = 1'b0; tmr1_ovf = 1'b0; tmr2_ovf = 1'b0;
      chk("R3/R4 vec_req", vec_req, VEC[v][3]);
      if (VEC[v][3]) begin
        chk("R5 vec_idx", vec_idx, VEC[v][2:0]);
        chk("R5 vec_addr", vec_addr, 8'(VEC[v][2:0]) * 8 + 3);
      end
      ser_req = 1'b0;
    end
    drain();

    // R9 control byte write
    wr_ctl(8'h55);
    chk("R9 ctl_q", ctl_q, 8'h55);
    wr_ctl(8'h00);

    // R6 + R12 edge mode on external 0
    wr_ctl(8'h05);
    wr_en(8'h85);
    ext0_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R12 flag not yet", ctl_q[1], 1'b0);
    @(negedge clk);
    chk("R12 flag after 3 edges", ctl_q[1], 1'b1);
    ext0_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 latched", ctl_q[1], 1'b1);
    chk("R6 vec_addr ext0", vec_addr, 8'h03);
    ack();
    chk("R6 cleared on ack", ctl_q[1], 1'b0);
    chk("R11 busy after ack", vec_req, 1'b0);

    // R11 event during service on external 1
    ext1_n = 1'b0;
    repeat (4) @(negedge clk);
    ext1_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 held while busy", vec_req, 1'b0);
    done();
    chk("R11 after release", vec_req, 1'b1);
    chk("R11 vec_addr ext1", vec_addr, 8'h13);
    ack();
    done();
    chk("R6 ext1 cleared", ctl_q[3], 1'b0);

    // R7 level mode
    wr_ctl(8'h00);
    wr_en(8'h81);
    ext0_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R12 level not yet", ctl_q[1], 1'b0);
    @(negedge clk);
    chk("R7 level flag", ctl_q[1], 1'b1);
    chk("R7 vec_idx", vec_idx, 3'd0);
    ack();
    chk("R7 not cleared by ack", ctl_q[1], 1'b1);
    done();
    ext0_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 follows pin", ctl_q[1], 1'b0);
    chk("R7 no req", vec_req, 1'b0);

    // R10 serial
    wr_en(8'h90);
    ser_req = 1'b1;
    @(negedge clk);
    ack();
    done();
    chk("R10 still requesting", vec_req, 1'b1);
    chk("R10 vec_idx", vec_idx, 3'd4);
    ser_req = 1'b0;
    @(negedge clk);
    chk("R10 drops with input", vec_req, 1'b0);

    // R8 overflow wins over ack and over write
    wr_en(8'h82);
    tmr0_ovf = 1'b1;
    @(negedge clk);
    tmr0_ovf = 1'b0;
    chk("R8 set", ctl_q[5], 1'b1);
    vec_ack = 1'b1; tmr0_ovf = 1'b1;
    @(negedge clk);
    vec_ack = 1'b0; tmr0_ovf = 1'b0;
    chk("R8 ovf beats ack", ctl_q[5], 1'b1);
    done();
    ack();
    chk("R8 cleared on ack", ctl_q[5], 1'b0);
    done();
    ctl_we = 1'b1; ctl_wdata = 8'h00; tmr1_ovf = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0; tmr1_ovf = 1'b0;
    chk("R8 ovf beats write", ctl_q[7], 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule